// File: doc/BRIEF.md
# Fault Delay Up/Down Counter

This block turns a set of supervisor fault indications into one delayed fault line. A saturating up/down counter measures how long a fault has been present or absent. A small output state machine raises the line when the counter reaches its terminal count and drops it again when the counter returns to zero. So both the assert and the release of the line are delayed by the same span, measured by one counter running in opposite directions. With a 10 kHz monitor clock the default terminal count of 4000 gives a delay of about 400 ms in each direction.

The inputs are three fault flags: supply undervoltage, supply overvoltage and watchdog failure. A fault flag drives the counter up. When no flag is set and the watchdog reports recovery, the counter runs down. When neither condition holds, the counter keeps its value. Two inputs override this. A standby request ignores the faults and forces a delayed release. A loss of supply-good drops the line in the same cycle and clears the counter.

The output state machine has three states. ST_SAFE has the line low. ST_TRIPPED has the line high. ST_DEAD means supply is lost, and the line is low. The transitions are:
- ST_SAFE to ST_TRIPPED when the count is at its terminal value.
- ST_TRIPPED to ST_SAFE when the count is zero.
- Any state to ST_DEAD when supply-good is low.
- ST_DEAD to ST_SAFE when supply-good returns.

The counter direction is chosen by a priority arbiter. DIR_CLEAR is chosen when supply is lost. DIR_DOWN is chosen in standby. DIR_UP is chosen when any fault flag is set. DIR_DOWN is also chosen when the watchdog reports recovery. DIR_HOLD is chosen otherwise.

Top module: `fault_delay_ctrl`

## Requirements
- R1: While `supply_ok`=1 and `standby`=0, any of `vcc_low`, `vcc_high` or `wd_fail` at 1 increments the count by one per clock, up to TERM_COUNT.
- R2: Starting from a count of zero with a fault held, `fault_out` stays 0 for TERM_COUNT rising edges and reads 1 after TERM_COUNT+1 edges (it rises on the edge after the count reaches TERM_COUNT).
- R3: The count decrements only when no fault flag is set and `wd_recovered`=1, or in standby. A fault flag wins over `wd_recovered`.
- R4: Counting down from TERM_COUNT, `fault_out` stays 1 for TERM_COUNT edges and reads 0 after TERM_COUNT+1 edges (it falls on the edge after the count reaches zero).
- R5: With `supply_ok`=1, `standby`=0, no fault flag and `wd_recovered`=0, the count and `fault_out` hold their values.
- R6: The count saturates at TERM_COUNT and at zero. Holding a direction beyond the end does not lengthen the following delay in the other direction.
- R7: With `supply_ok`=0, `fault_out` is 0 in the same cycle, with no clock edge needed. The count is cleared to zero, so a fault after supply returns needs the full TERM_COUNT+1 edges.
- R8: With `standby`=1 and `supply_ok`=1, the fault flags are ignored, the count runs down, and `fault_out` falls after the release delay of R4.
- R9: Asynchronous active-low `rst_n` clears the count and forces `fault_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good indication; 0 disables the block at once |
| standby | input | 1 | Standby request (ignition off) |
| vcc_low | input | 1 | Undervoltage fault flag |
| vcc_high | input | 1 | Overvoltage fault flag |
| wd_fail | input | 1 | Watchdog failure flag |
| wd_recovered | input | 1 | Watchdog recovery indication |
| fault_out | output | 1 | Delayed fault line |

## Verification
The assertions check the per-cycle rules on every clock:
- the single step up or down and the hold, chosen by the input priority;
- that the count never leaves the range zero to TERM_COUNT;
- that the line only rises after a terminal count and only falls at zero;
- the forced-low state while supply is lost.

Only the bench scenarios can show the end-to-end delays. These are the exact TERM_COUNT+1 edge spacing, the absence of any extra delay after long saturation, and that a count paused by a hold resumes where it stopped. The scenarios also show that standby masks live faults over a long interval, and that a count cleared by supply loss or reset makes the next trip take the full span.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
    typedef enum logic [1:0] {
        DIR_HOLD  = 2'd0,
        DIR_UP    = 2'd1,
        DIR_DOWN  = 2'd2,
        DIR_CLEAR = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        ST_SAFE    = 2'd0,
        ST_TRIPPED = 2'd1,
        ST_DEAD    = 2'd2
    } out_st_e;
endpackage

// File: rtl/fdc_direction.sv
module fdc_direction
    import fdc_pkg::*;
(
    input  logic supply_ok,
    input  logic standby,
    input  logic vcc_low,
    input  logic vcc_high,
    input  logic wd_fail,
    input  logic wd_recovered,
    output dir_e dir
);
    logic any_fault;

    assign any_fault = vcc_low | vcc_high | wd_fail;

    // Priority: supply loss, standby, fault, recovery, hold
    always_comb begin
        if (!supply_ok) begin
            dir = DIR_CLEAR;
        end else if (standby) begin
            dir = DIR_DOWN;
        end else if (any_fault) begin
            dir = DIR_UP;
        end else if (wd_recovered) begin
            dir = DIR_DOWN;
        end else begin
            dir = DIR_HOLD;
        end
    end
endmodule

// File: rtl/fdc_counter.sv
module fdc_counter
    import fdc_pkg::*;
#(
    parameter int unsigned TERM_COUNT = 4000,
    parameter int unsigned CNT_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dir_e             dir,
    output logic [CNT_W-1:0] cnt,
    output logic             at_top,
    output logic             at_zero
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(TERM_COUNT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        unique case (dir)
            DIR_UP:    if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
            DIR_DOWN:  if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
            DIR_CLEAR: cnt_d = '0;
            DIR_HOLD:  cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt     = cnt_q;
    assign at_top  = (cnt_q == TOP);
    assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/fdc_out_fsm.sv
module fdc_out_fsm
    import fdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic at_top,
    input  logic at_zero,
    output logic fault_out
);
    out_st_e state_q;
    out_st_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAFE:    if (at_top)  state_d = ST_TRIPPED;
            ST_TRIPPED: if (at_zero) state_d = ST_SAFE;
            ST_DEAD:    state_d = ST_SAFE;
            default:    state_d = ST_SAFE;
        endcase
        if (!supply_ok) state_d = ST_DEAD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SAFE;
        else        state_q <= state_d;
    end

    // Supply loss gates the line without waiting for an edge
    always_comb begin
        unique case (state_q)
            ST_TRIPPED: fault_out = supply_ok;
            ST_SAFE:    fault_out = 1'b0;
            ST_DEAD:    fault_out = 1'b0;
            default:    fault_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/fault_delay_ctrl.sv
module fault_delay_ctrl
    import fdc_pkg::*;
#(
    parameter int unsigned TERM_COUNT = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic standby,
    input  logic vcc_low,
    input  logic vcc_high,
    input  logic wd_fail,
    input  logic wd_recovered,
    output logic fault_out
);
    localparam int unsigned CNT_W = $clog2(TERM_COUNT + 1);

    dir_e             dir;
    logic [CNT_W-1:0] cnt_q;
    logic             at_top;
    logic             at_zero;

    fdc_direction u_dir (
        .supply_ok    (supply_ok),
        .standby      (standby),
        .vcc_low      (vcc_low),
        .vcc_high     (vcc_high),
        .wd_fail      (wd_fail),
        .wd_recovered (wd_recovered),
        .dir          (dir)
    );

    fdc_counter #(
        .TERM_COUNT (TERM_COUNT),
        .CNT_W      (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir     (dir),
        .cnt     (cnt_q),
        .at_top  (at_top),
        .at_zero (at_zero)
    );

    fdc_out_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .at_top    (at_top),
        .at_zero   (at_zero),
        .fault_out (fault_out)
    );
endmodule

// File: rtl/fdc_checker.sv
module fdc_checker #(
    parameter int unsigned TERM_COUNT = 4000,
    parameter int unsigned CNT_W      = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             supply_ok,
    input logic             standby,
    input logic             vcc_low,
    input logic             vcc_high,
    input logic             wd_fail,
    input logic             wd_recovered,
    input logic [CNT_W-1:0] cnt,
    input logic             fault_out
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(TERM_COUNT);

    logic flt;
    assign flt = vcc_low | vcc_high | wd_fail;

    a_r1_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !standby && flt && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));

    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && (standby || (!flt && wd_recovered)) && cnt != '0)
        |=> (cnt == $past(cnt) - 1'b1));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !standby && !flt && !wd_recovered) |=> $stable(cnt));

    a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);

    a_r2_rise_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_out) |-> ($past(cnt) == TOP));

    a_r4_fall_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && $past(supply_ok) && $fell(fault_out)) |-> ($past(cnt) == '0));

    a_r7_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (cnt == '0));

    a_r7_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> !fault_out);
endmodule

bind fault_delay_ctrl fdc_checker #(
    .TERM_COUNT (TERM_COUNT),
    .CNT_W      (CNT_W)
) u_fdc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .standby      (standby),
    .vcc_low      (vcc_low),
    .vcc_high     (vcc_high),
    .wd_fail      (wd_fail),
    .wd_recovered (wd_recovered),
    .cnt          (cnt_q),
    .fault_out    (fault_out)
);

// File: tb/fault_delay_ctrl_tb.sv
module fault_delay_ctrl_tb_top;
    localparam int TC = 16;

    logic clk = 1'b0;
    logic rst_n, supply_ok, standby, vcc_low, vcc_high, wd_fail, wd_recovered;
    logic fault_out;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    always #2 clk = ~clk;

    fault_delay_ctrl #(.TERM_COUNT(TC)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok    (supply_ok),
        .standby      (standby),
        .vcc_low      (vcc_low),
        .vcc_high     (vcc_high),
        .wd_fail      (wd_fail),
        .wd_recovered (wd_recovered),
        .fault_out    (fault_out)
    );

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp);
        checks++;
        if (fault_out !== exp) begin
            errors++;
            $display("FAIL %s fault_out actual=%b expected=%b t=%0t", req, fault_out, exp, $time);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; supply_ok = 1'b1; standby = 1'b0; vcc_low = 1'b0;
        vcc_high = 1'b0; wd_fail = 1'b0; wd_recovered = 1'b0;
        run(3);
        check("R9 reset low", 1'b0);
        rst_n = 1'b1;
        run(5);
        check("R9 idle after reset", 1'b0);
    endtask

    task automatic t_trip_and_saturate;
        vcc_low = 1'b1;
        run(TC);     check("R2 low before delay", 1'b0);
        run(1);      check("R1 R2 undervoltage trips", 1'b1);
        wd_recovered = 1'b1;
        run(3 * TC); check("R3 fault wins over recovery", 1'b1);
        vcc_low = 1'b0;
        run(TC);     check("R4 high before release", 1'b1);
        run(1);      check("R4 R6 release after exact delay", 1'b0);
        run(3 * TC); check("R6 stays low at zero", 1'b0);
        wd_recovered = 1'b0; vcc_high = 1'b1;
        run(TC);     check("R6 no extra margin below zero", 1'b0);
        run(1);      check("R1 overvoltage trips", 1'b1);
        vcc_high = 1'b0;
    endtask

    task automatic t_hold;
        run(50);     check("R5 hold keeps high", 1'b1);
        wd_recovered = 1'b1; run(5);
        wd_recovered = 1'b0; run(40);
        check("R5 hold mid count", 1'b1);
        wd_recovered = 1'b1;
        run(TC - 5); check("R5 resumed down not yet low", 1'b1);
        run(1);      check("R5 resumed down reaches zero", 1'b0);
        wd_recovered = 1'b0; wd_fail = 1'b1; run(6);
        wd_fail = 1'b0; run(30);
        check("R5 hold partial up", 1'b0);
        wd_fail = 1'b1;
        run(TC - 6); check("R5 resumed up not yet high", 1'b0);
        run(1);      check("R1 watchdog failure trips", 1'b1);
    endtask

    task automatic t_standby;
        standby = 1'b1;
        run(TC);     check("R8 standby high before delay", 1'b1);
        run(1);      check("R8 standby release", 1'b0);
        run(2 * TC); check("R8 faults ignored in standby", 1'b0);
        standby = 1'b0;
        run(TC);     check("R8 count left at zero", 1'b0);
        run(1);      check("R8 trip after standby exit", 1'b1);
    endtask

    task automatic t_supply;
        supply_ok = 1'b0;
        #1;          check("R7 low in same cycle", 1'b0);
        run(5);      check("R7 stays low", 1'b0);
        supply_ok = 1'b1;
        run(TC);     check("R7 restart from zero", 1'b0);
        run(1);      check("R7 trip after restore", 1'b1);
        wd_fail = 1'b0; wd_recovered = 1'b1;
        run(TC + 1); check("R4 release before partial test", 1'b0);
        wd_recovered = 1'b0; wd_fail = 1'b1;
        run(TC - 2);
        supply_ok = 1'b0; run(2);
        supply_ok = 1'b1;
        run(TC);     check("R7 partial count cleared", 1'b0);
        run(1);      check("R7 full delay after clear", 1'b1);
    endtask

    task automatic t_async_reset;
        rst_n = 1'b0;
        #1;          check("R9 async reset low", 1'b0);
        run(1);
        rst_n = 1'b1;
        run(TC);     check("R9 count cleared by reset", 1'b0);
        run(1);      check("R9 trip after reset", 1'b1);
    endtask

    initial begin
        t_reset;
        t_trip_and_saturate;
        t_hold;
        t_standby;
        t_supply;
        t_async_reset;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule